// File: doc/BRIEF.md
# I2C Serial EEPROM Target Model

This block is a synthesizable I2C target that looks to a bus master like a small serial EEPROM with byte addressing. It is meant to sit next to an I2C master under test, in simulation or on a board, so that the master's write, random-read and sequential-read sequences can be checked against a memory that reacts the way such a part does. Both bus lines are sampled on a fast system clock. The block never drives SDA high: it only raises an output-enable that tells the pad to pull the line low.

A write places the bytes that follow the word address into a small holding buffer. They reach the 256-byte array only when the master ends the transfer with a stop. Only then does the block enter a programming interval of a set number of system clocks, during which it does not answer on the bus. A read returns bytes from the array starting at the current word pointer, and moves on to the next location each time the master acknowledges.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, and whenever no transfer is under way, `sdaOe` is 0, so SDA is released.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A start begins a new device-select byte from any state, which is how a repeated start is handled.
- R3: Bytes arrive MSB first. The first byte after a start is acknowledged by pulling SDA low during the ninth SCL clock only if its upper seven bits equal `DEV_ADDR` (default 7'b1010000). Its bit 0 selects the direction: 0 is write, 1 is read. Any other byte gets no acknowledge, and the block stays silent until the next start.
- R4: After a write select, the next byte loads the word pointer. Each data byte after that is acknowledged and is assigned to the pointer's location. The pointer then increments and wraps from 255 to 0.
- R5: Data bytes from a write reach the array only when a stop arrives. A start that comes before the stop throws them away.
- R6: The holding buffer stores up to `BUF_DEPTH` data bytes per write. Further data bytes get no acknowledge, are discarded and leave the pointer unchanged.
- R7: A stop that ends a write with at least one stored data byte starts a programming interval of `PROG_CYCLES` system clocks. During that interval no device select is acknowledged. A stop that ends a write with no data bytes starts no interval.
- R8: A random read is a write select, a word address, a repeated start and a read select. It returns the byte at that address, MSB first.
- R9: A master acknowledge (SDA low on the ninth clock) after a read byte makes the block send the byte at the next address, wrapping from 255 to 0.
- R10: A master no-acknowledge (SDA high on the ninth clock) ends the read. SDA stays released through any further clocks until a start or a stop.
- R11: `sdaOe` changes only after a detected SCL falling edge, so SDA holds steady while SCL is high.
- R12: A read select with no word address before it reads from the pointer that the previous write or read left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | SCL line level as seen at the pad |
| sdaIn | input | 1 | SDA line level as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume the master follows the bus rules. SDA changes only while SCL is low, except to form a start or a stop. Each SCL phase lasts several system clocks longer than the two-flop synchronizer delay. The master never makes a start or stop while the target is holding SDA low. The bench master is a task-driven model whose quarter-bit period is five system clocks. It changes SDA only in the SCL-low quarter, releases SDA whenever the target owns it, and puts every start and stop on a fully high SCL phase. Random transfers keep to these rules while varying the address, the length (including lengths past the buffer capacity) and the data.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK_W,
    ST_DEV_ACK_R,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_RACK
  } busState_e;

  // strobes from the bus controller to the datapath
  typedef struct packed {
    logic rxBit;     // synchronized SDA level
    logic shIn;      // shift rxBit into the receive register
    logic ldAddr;    // received byte becomes the word pointer
    logic bufPush;   // received byte goes into the holding buffer
    logic clrBuf;    // drop the holding buffer
    logic ldOut;     // fetch byte at pointer, drive its MSB
    logic shOut;     // advance to next transmit bit
    logic ackDrive;  // pull SDA low for an acknowledge
    logic relSda;    // release SDA
    logic progGo;    // stop seen: commit buffer if it holds data
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1010000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rxByte,
  input  logic       busy,
  input  logic       bufFull,
  output dpStrobe_t  strb,
  output busState_e  state,
  output logic       sclSync,
  output logic       stopSeen
);

  logic [1:0] sclPipe, sdaPipe;
  logic       sclDly, sdaDly;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startDet, stopDet;

  busState_e  stateNext;
  logic [3:0] bitCnt, bitCntNext;
  logic       mAck, mAckNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclDly  <= 1'b1;
      sdaDly  <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], sclIn};
      sdaPipe <= {sdaPipe[0], sdaIn};
      sclDly  <= sclPipe[1];
      sdaDly  <= sdaPipe[1];
    end
  end

  assign sclS     = sclPipe[1];
  assign sdaS     = sdaPipe[1];
  assign sclRise  = sclS & ~sclDly;
  assign sclFall  = ~sclS & sclDly;
  assign startDet = sclS & sclDly & sdaDly & ~sdaS;
  assign stopDet  = sclS & sclDly & ~sdaDly & sdaS;
  assign sclSync  = sclS;
  assign stopSeen = stopDet;

  always_comb begin
    strb       = '0;
    strb.rxBit = sdaS;
    stateNext  = state;
    bitCntNext = bitCnt;
    mAckNext   = mAck;
    if (stopDet) begin
      stateNext   = ST_IDLE;
      strb.relSda = 1'b1;
      strb.progGo = ~busy;
    end else if (startDet) begin
      strb.relSda = 1'b1;
      if (!busy) begin
        stateNext    = ST_DEV;
        bitCntNext   = '0;
        strb.clrBuf  = 1'b1;
      end else begin
        stateNext = ST_IDLE;
      end
    end else begin
      case (state)
        ST_DEV, ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            strb.shIn  = 1'b1;
            bitCntNext = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            bitCntNext = '0;
            case (state)
              ST_DEV: begin
                if (rxByte[7:1] == DEV_ADDR && !busy) begin
                  strb.ackDrive = 1'b1;
                  stateNext     = rxByte[0] ? ST_DEV_ACK_R : ST_DEV_ACK_W;
                end else begin
                  stateNext = ST_IDLE;
                end
              end
              ST_ADDR: begin
                strb.ackDrive = 1'b1;
                strb.ldAddr   = 1'b1;
                stateNext     = ST_ADDR_ACK;
              end
              default: begin
                if (!bufFull) begin
                  strb.ackDrive = 1'b1;
                  strb.bufPush  = 1'b1;
                  stateNext     = ST_WDATA_ACK;
                end else begin
                  stateNext = ST_IDLE;
                end
              end
            endcase
          end
        end
        ST_DEV_ACK_W: if (sclFall) begin
          strb.relSda = 1'b1;
          stateNext   = ST_ADDR;
        end
        ST_ADDR_ACK, ST_WDATA_ACK: if (sclFall) begin
          strb.relSda = 1'b1;
          stateNext   = ST_WDATA;
        end
        ST_DEV_ACK_R: if (sclFall) begin
          strb.ldOut = 1'b1;
          bitCntNext = '0;
          stateNext  = ST_TX;
        end
        ST_TX: begin
          if (sclRise) begin
            bitCntNext = bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              strb.relSda = 1'b1;
              bitCntNext  = '0;
              stateNext   = ST_RACK;
            end else begin
              strb.shOut = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            mAckNext = ~sdaS;
          end else if (sclFall) begin
            if (mAck) begin
              strb.ldOut = 1'b1;
              bitCntNext = '0;
              stateNext  = ST_TX;
            end else begin
              stateNext = ST_IDLE;
            end
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateNext;
      bitCnt <= bitCntNext;
      mAck   <= mAckNext;
    end
  end

endmodule

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUF_DEPTH   = 16,
  parameter int PROG_CYCLES = 600000
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strb,
  output logic [7:0] rxByte,
  output logic       busy,
  output logic       bufFull,
  output logic       sdaOe
);

  localparam int MEM_DEPTH = 1 << ADDR_W;
  localparam int IDX_W     = $clog2(BUF_DEPTH);
  localparam int CNT_W     = $clog2(BUF_DEPTH + 1);
  localparam int PROG_EFF  = (PROG_CYCLES > BUF_DEPTH) ? PROG_CYCLES : BUF_DEPTH;
  localparam int PROG_W    = $clog2(PROG_EFF + 1);

  logic [7:0]        mem    [MEM_DEPTH];
  logic [7:0]        bufMem [BUF_DEPTH];
  logic [CNT_W-1:0]  bufCnt, commitIdx;
  logic [ADDR_W-1:0] bufBase, wordPtr, commitAddr;
  logic [PROG_W-1:0] progCnt;
  logic [7:0]        rxShift, txShift, memOut;
  logic              sdaOeR, committing;

  assign committing = (progCnt != '0) && (commitIdx < bufCnt);
  assign commitAddr = bufBase + ADDR_W'(commitIdx);
  assign memOut     = mem[wordPtr];

  // array: filled from the holding buffer, one byte per clock, during the interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= 8'hFF;
    end else if (committing) begin
      mem[commitAddr] <= bufMem[commitIdx[IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.bufPush) bufMem[bufCnt[IDX_W-1:0]] <= rxShift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufCnt    <= '0;
      bufBase   <= '0;
      commitIdx <= '0;
      progCnt   <= '0;
    end else begin
      if (progCnt != '0) progCnt <= progCnt - 1'b1;
      else if (strb.progGo && bufCnt != '0) progCnt <= PROG_W'(PROG_EFF);

      if (strb.progGo && progCnt == '0) commitIdx <= '0;
      else if (committing) commitIdx <= commitIdx + 1'b1;

      if (strb.clrBuf) begin
        bufCnt <= '0;
      end else if (strb.bufPush) begin
        if (bufCnt == '0) bufBase <= wordPtr;
        bufCnt <= bufCnt + 1'b1;
      end else if (progCnt == PROG_W'(1)) begin
        bufCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordPtr <= '0;
      rxShift <= '0;
      txShift <= '0;
      sdaOeR  <= 1'b0;
    end else begin
      if (strb.shIn) rxShift <= {rxShift[6:0], strb.rxBit};

      if (strb.ldAddr) wordPtr <= rxShift[ADDR_W-1:0];
      else if (strb.bufPush || strb.ldOut) wordPtr <= wordPtr + 1'b1;

      if (strb.ldOut) txShift <= memOut;
      else if (strb.shOut) txShift <= {txShift[6:0], 1'b0};

      if (strb.relSda) sdaOeR <= 1'b0;
      else if (strb.ackDrive) sdaOeR <= 1'b1;
      else if (strb.ldOut) sdaOeR <= ~memOut[7];
      else if (strb.shOut) sdaOeR <= ~txShift[6];
    end
  end

  assign rxByte  = rxShift;
  assign busy    = (progCnt != '0);
  assign bufFull = (bufCnt == CNT_W'(BUF_DEPTH));
  assign sdaOe   = sdaOeR;

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010000,
  parameter int         ADDR_W      = 8,
  parameter int         BUF_DEPTH   = 16,
  parameter int         PROG_CYCLES = 600000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe
);

  dpStrobe_t  strb;
  busState_e  state;
  logic       sclSync, stopSeen, busy, bufFull;
  logic [7:0] rxByte;

  eeprom_ctrl #(
    .DEV_ADDR (DEV_ADDR)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .rxByte   (rxByte),
    .busy     (busy),
    .bufFull  (bufFull),
    .strb     (strb),
    .state    (state),
    .sclSync  (sclSync),
    .stopSeen (stopSeen)
  );

  eeprom_dp #(
    .ADDR_W      (ADDR_W),
    .BUF_DEPTH   (BUF_DEPTH),
    .PROG_CYCLES (PROG_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rxByte  (rxByte),
    .busy    (busy),
    .bufFull (bufFull),
    .sdaOe   (sdaOe)
  );

endmodule

// File: rtl/eeprom_checker.sv
module eeprom_checker
  import eeprom_pkg::*;
#(
  parameter int BUF_DEPTH   = 16,
  parameter int PROG_CYCLES = 600000
) (
  input logic      clk,
  input logic      rstN,
  input logic      sdaOe,
  input logic      sclSync,
  input logic      busy,
  input logic      stopSeen,
  input busState_e state
);

  localparam int PROG_EFF = (PROG_CYCLES > BUF_DEPTH) ? PROG_CYCLES : BUF_DEPTH;

  int busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else busyRun <= 0;
  end

  a_r11_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclSync);

  a_r7_silent_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  a_r7_busy_follows_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopSeen));

  a_r7_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < PROG_EFF));

  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);

endmodule

bind i2c_eeprom_target eeprom_checker #(
  .BUF_DEPTH   (BUF_DEPTH),
  .PROG_CYCLES (PROG_CYCLES)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .sdaOe    (sdaOe),
  .sclSync  (sclSync),
  .busy     (busy),
  .stopSeen (stopSeen),
  .state    (state)
);

// File: tb/i2c_eeprom_target_bench.sv
`timescale 1ns / 1ps
module i2c_eeprom_target_bench;

  localparam int BD   = 8;
  localparam int PROG = 3000;
  localparam int Q    = 5;
  localparam int WD   = 180000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaOe;

  always #2.5 clk = ~clk;

  i2c_eeprom_target #(
    .DEV_ADDR    (7'b1010000),
    .ADDR_W      (8),
    .BUF_DEPTH   (BD),
    .PROG_CYCLES (PROG)
  ) u_i2c_eeprom_target (
    .clk   (clk),
    .rstN  (rstN),
    .sclIn (sclM),
    .sdaIn (sdaLine),
    .sdaOe (sdaOe)
  );

  int nChk = 0;
  int nFail = 0;
  logic [7:0] model [256];
  logic [7:0] ptr = 8'h00;
  logic [7:0] wbuf [32];

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  function automatic bit expectDataAck(input int idx);
    return idx < BD;
  endfunction

  task automatic busStart();
    sdaM = 1'b1; wq(Q);
    sclM = 1'b1; wq(2 * Q);
    sdaM = 1'b0; wq(2 * Q);
    sclM = 1'b0; wq(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; wq(Q);
    sclM = 1'b1; wq(2 * Q);
    sdaM = 1'b1; wq(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; wq(Q);
      sclM = 1'b1; wq(2 * Q);
      sclM = 1'b0; wq(Q);
    end
    sdaM = 1'b1; wq(Q);
    sclM = 1'b1; wq(Q);
    acked = !sdaLine;
    wq(Q);
    sclM = 1'b0; wq(Q);
  endtask

  task automatic readByte(input bit mAck, output logic [7:0] b, output bit steady);
    logic s0;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1'b1; wq(Q);
      sclM = 1'b1; wq(1);
      s0 = sdaLine; wq(Q - 1);
      b[i] = sdaLine;
      if (b[i] != s0) steady = 1'b0;
      wq(Q - 1);
      if (sdaLine != s0) steady = 1'b0;
      wq(1);
      sclM = 1'b0; wq(Q);
    end
    sdaM = mAck ? 1'b0 : 1'b1; wq(Q);
    sclM = 1'b1; wq(2 * Q);
    sclM = 1'b0; wq(Q);
  endtask

  // write select, address, n data bytes from wbuf, stop; model updated at stop
  task automatic doWrite(input logic [7:0] a, input int n);
    bit ack;
    int kept;
    busStart();
    sendByte(8'hA0, ack); chk(ack, "R3 write select ack", {7'd0, ack}, 8'h01);
    sendByte(a, ack);     chk(ack, "R4 word address ack", {7'd0, ack}, 8'h01);
    ptr = a;
    kept = 0;
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], ack);
      if (expectDataAck(k)) chk(ack, "R4 data ack", {7'd0, ack}, 8'h01);
      else chk(!ack, "R6 overflow byte not acked", {7'd0, ack}, 8'h00);
      if (expectDataAck(k)) kept++;
    end
    busStop();
    for (int k = 0; k < kept; k++) begin
      model[ptr] = wbuf[k];
      ptr = ptr + 8'd1;
    end
  endtask

  task automatic readN(input int n);
    logic [7:0] got;
    bit steady;
    for (int k = 0; k < n; k++) begin
      readByte(k != n - 1, got, steady);
      chk(got == model[ptr], "R8 R9 read data", got, model[ptr]);
      chk(steady, "R11 SDA steady while SCL high", {7'd0, steady}, 8'h01);
      ptr = ptr + 8'd1;
    end
  endtask

  task automatic doRandomRead(input logic [7:0] a, input int n);
    bit ack;
    busStart();
    sendByte(8'hA0, ack); chk(ack, "R8 dummy write select ack", {7'd0, ack}, 8'h01);
    sendByte(a, ack);     chk(ack, "R8 read address ack", {7'd0, ack}, 8'h01);
    ptr = a;
    busStart();
    sendByte(8'hA1, ack); chk(ack, "R8 read select ack", {7'd0, ack}, 8'h01);
    readN(n);
    busStop();
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    summary();
  end

  initial begin
    bit ack;
    logic [7:0] got;
    bit steady;
    logic [7:0] a;
    int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) model[i] = 8'hFF;

    wq(10);
    rstN = 1'b1;
    wq(10);
    // R1: released after reset
    chk(sdaOe == 1'b0, "R1 released after reset", {7'd0, sdaOe}, 8'h00);

    // R3: foreign device selects get no ack, following bytes ignored
    busStart();
    sendByte(8'hB0, ack); chk(!ack, "R3 foreign select", {7'd0, ack}, 8'h00);
    sendByte(8'h00, ack); chk(!ack, "R3 byte after foreign select", {7'd0, ack}, 8'h00);
    busStop();
    busStart();
    sendByte(8'hA2, ack); chk(!ack, "R3 wrong low address bit", {7'd0, ack}, 8'h00);
    busStop();
    chk(sdaOe == 1'b0, "R1 released when idle", {7'd0, sdaOe}, 8'h00);

    // R5: repeated start before stop drops buffered bytes
    busStart();
    sendByte(8'hA0, ack); chk(ack, "R2 start then select ack", {7'd0, ack}, 8'h01);
    sendByte(8'h20, ack); chk(ack, "R4 address ack", {7'd0, ack}, 8'h01);
    sendByte(8'h11, ack); chk(ack, "R4 data ack", {7'd0, ack}, 8'h01);
    sendByte(8'h22, ack); chk(ack, "R4 data ack", {7'd0, ack}, 8'h01);
    busStart();
    sendByte(8'hA0, ack); chk(ack, "R2 repeated start select ack", {7'd0, ack}, 8'h01);
    sendByte(8'h20, ack);
    ptr = 8'h20;
    busStart();
    sendByte(8'hA1, ack); chk(ack, "R7 no interval without commit", {7'd0, ack}, 8'h01);
    readN(2);
    busStop();
    // R7: address-only write then stop starts no interval
    busStart();
    sendByte(8'hA0, ack);
    sendByte(8'h40, ack);
    busStop();
    busStart();
    sendByte(8'hA0, ack); chk(ack, "R7 no interval after address-only write", {7'd0, ack}, 8'h01);
    busStop();

    // R4 wrap write, R7 busy poll, R9 wrap read, R12 current address read
    wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
    doWrite(8'hFE, 4);
    busStart();
    sendByte(8'hA0, ack); chk(!ack, "R7 select ignored while programming", {7'd0, ack}, 8'h00);
    busStop();
    wq(PROG + 50);
    doRandomRead(8'hFE, 3);
    busStart();
    sendByte(8'hA1, ack); chk(ack, "R12 current read select ack", {7'd0, ack}, 8'h01);
    readByte(1'b0, got, steady);
    chk(got == model[ptr], "R12 current address read", got, model[ptr]);
    ptr = ptr + 8'd1;
    busStop();

    // R10: after master NACK the target stays off the bus
    wbuf[0] = 8'h00; wbuf[1] = 8'h5A;
    doWrite(8'h30, 2);
    wq(PROG + 50);
    doRandomRead(8'h30, 1);
    busStart();
    sendByte(8'hA0, ack);
    sendByte(8'h30, ack);
    busStart();
    sendByte(8'hA1, ack);
    readByte(1'b0, got, steady);
    chk(got == 8'h00, "R10 byte before NACK", got, 8'h00);
    readByte(1'b0, got, steady);
    chk(got == 8'hFF, "R10 silent after NACK", got, 8'hFF);
    busStop();
    chk(sdaOe == 1'b0, "R10 released after NACK", {7'd0, sdaOe}, 8'h00);

    // random write/read rounds; first one overruns the buffer (R6)
    for (int it = 0; it < 8; it++) begin
      a = 8'($urandom % 256);
      n = (it == 0) ? BD + 2 : 1 + int'($urandom % (BD + 2));
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      doWrite(a, n);
      wq(PROG + 50);
      doRandomRead(a, n);
    end

    summary();
  end

endmodule